// File: doc/BRIEF.md
# Serial Memory Continuous-Read Front End

This block sits between a four-wire serial peripheral bus (clock polarity 0, phase 0) and a synchronous byte-wide storage array. It runs entirely in the system clock domain: the serial clock, chip select and serial data input are brought in through synchronizer flops, and their edges are detected there. While chip select is low, the block collects an 8-bit command and a 16-bit address on the serial input. If the command is the read command, it fetches the addressed byte from the array and streams it out most significant bit first. After each byte it advances the address, and output continues for as long as the bus master keeps clocking.

Array fetches leave on a valid/ready request channel and come back on a response channel. A request holds its valid and its address until the cycle in which ready is seen high, and the handshake completes on that edge. The array returns the byte with a single-cycle response valid, at any point after the handshake. That response must arrive before the next serial falling edge. The array port has no response back-pressure. The next byte is requested while the last bit of the current byte is on the wire, so there is one serial bit period of slack in which to absorb request stalls. An unknown command silences the block until chip select goes high again.

Top module: `srd_read_seq`

## Requirements
- R1: While chip select is high, `miso_oe` is 0 and no array request is raised. After chip select rises, `miso_oe` is 0 within 5 system clocks.
- R2: The read command is the byte 0x03, sent MSB first. It is followed by a 16-bit address, sent MSB first. Only the low log2(DEPTH) bits select the location, and the upper address bits are ignored.
- R3: Data bits are driven MSB first. `miso_o` changes only after a detected falling serial clock edge. The first data bit appears on the falling edge that follows the last address bit. `miso_oe` is 0 during the command and address bytes and 1 throughout the data phase.
- R4: After each byte the address advances by one, and consecutive bytes follow with no idle bit between them.
- R5: Reading past location DEPTH-1 continues at location 0.
- R6: Serial input values during the data phase have no effect on the streamed data.
- R7: A command byte other than 0x03 causes no array request and leaves `miso_oe` at 0 until chip select rises. The next transaction is decoded normally.
- R8: Raising chip select part-way through a byte ends the read. A new read started afterwards returns the correct data.
- R9: A stream of N complete data bytes issues exactly N+1 array requests. A single-byte read therefore issues 2.
- R10: A request held while `mem_req_ready` is 0 keeps `mem_req_valid` high and `mem_req_addr` stable, and the streamed data is still correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out value |
| miso_oe | output | 1 | Output enable for the serial data out pad |
| mem_req_valid | output | 1 | Array read request valid |
| mem_req_ready | input | 1 | Array accepts the request |
| mem_req_addr | output | AW | Array location to read, AW = log2(DEPTH) |
| mem_rsp_valid | input | 1 | Array read data valid (one cycle) |
| mem_rsp_data | input | 8 | Array read data |

## Verification
Each serial edge reaches the logic two system clocks after the pin changes, and the result registers one clock after that. A new output bit is therefore steady about three clocks after a falling edge. The bench holds each serial half period for eight clocks and samples `miso_o` just before it raises the clock, as a real master would. Chip select release is judged five clocks after it rises, which covers its two synchronizer stages and the clearing register. Request counts are read after the last full byte, once the prefetch raised by that byte's final bit has had half a bit period to complete.

// File: rtl/srd_pkg.sv
package srd_pkg;

  localparam logic [7:0] CMD_READ = 8'h03;
  localparam int unsigned ADDR_BYTES = 2;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CMD  = 3'd1,
    ST_ADDR = 3'd2,
    ST_DATA = 3'd3,
    ST_SKIP = 3'd4
  } state_t;

endpackage

// File: rtl/srd_sync_edge.sv
module srd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic cs_n_in,
  input  logic mosi_in,
  output logic cs_n_s,
  output logic mosi_s,
  output logic sclk_rise,
  output logic sclk_fall
);

  localparam int NBITS = 3;
  localparam logic [NBITS-1:0] RST_VAL = 3'b010; // {mosi, cs_n, sclk}

  logic [NBITS-1:0] raw;
  logic [NBITS-1:0] synced;
  logic             sclk_prev;

  assign raw = {mosi_in, cs_n_in, sclk_in};

  genvar g;
  generate
    for (g = 0; g < NBITS; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
        else        chain <= {chain[STAGES-2:0], raw[g]};
      end
      assign synced[g] = chain[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= synced[0];
  end

  assign cs_n_s    = synced[1];
  assign mosi_s    = synced[2];
  assign sclk_rise = !cs_n_s && synced[0] && !sclk_prev;
  assign sclk_fall = !cs_n_s && !synced[0] && sclk_prev;

endmodule

// File: rtl/srd_rx_deser.sv
module srd_rx_deser #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              din,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_q
);

  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh;
  logic [CW-1:0]     cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      cnt       <= '0;
      byte_done <= 1'b0;
      byte_q    <= '0;
    end else if (clr) begin
      sh        <= '0;
      cnt       <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (shift_en) begin
        sh  <= {sh[BYTE_W-2:0], din};
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          byte_done <= 1'b1;
          byte_q    <= {sh[BYTE_W-2:0], din};
          cnt       <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/srd_tx_ser.sv
module srd_tx_ser #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic [BYTE_W-1:0] load_data,
  output logic              dout,
  output logic              oe,
  output logic              last_bit
);

  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh;
  logic [CW-1:0]     cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      cnt      <= '0;
      dout     <= 1'b0;
      oe       <= 1'b0;
      last_bit <= 1'b0;
    end else if (clr) begin
      sh       <= '0;
      cnt      <= '0;
      dout     <= 1'b0;
      oe       <= 1'b0;
      last_bit <= 1'b0;
    end else begin
      last_bit <= 1'b0;
      if (step) begin
        oe <= 1'b1;
        if (cnt == '0) begin
          dout <= load_data[BYTE_W-1];
          sh   <= {load_data[BYTE_W-2:0], 1'b0};
        end else begin
          dout <= sh[BYTE_W-1];
          sh   <= {sh[BYTE_W-2:0], 1'b0};
        end
        if (cnt == LAST) begin
          cnt      <= '0;
          last_bit <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/srd_read_seq.sv
module srd_read_seq #(
  parameter int DEPTH = 16384,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          mosi,
  output logic          miso_o,
  output logic          miso_oe,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [7:0]    mem_rsp_data
);

  import srd_pkg::*;

  localparam int AB_W = $clog2(ADDR_BYTES) + 1;
  localparam logic [AB_W-1:0] AB_LAST = AB_W'(ADDR_BYTES - 1);

  logic        cs_n_s;
  logic        mosi_s;
  logic        sclk_rise;
  logic        sclk_fall;
  logic        rx_done;
  logic [7:0]  rx_byte;
  logic        tx_last;
  logic        tx_step;
  logic        fetch_go;
  logic        addr_done;

  state_t          state;
  logic [AB_W-1:0] abyte_idx;
  logic [7:0]      addr_hi;
  logic [15:0]     addr_word;
  logic [AW-1:0]   next_addr;
  logic            pend;
  logic [7:0]      data_buf;

  srd_sync_edge #(.STAGES(2)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_in   (sclk),
    .cs_n_in   (cs_n),
    .mosi_in   (mosi),
    .cs_n_s    (cs_n_s),
    .mosi_s    (mosi_s),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall)
  );

  srd_rx_deser #(.BYTE_W(8)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cs_n_s),
    .shift_en  (sclk_rise),
    .din       (mosi_s),
    .byte_done (rx_done),
    .byte_q    (rx_byte)
  );

  assign tx_step = sclk_fall && (state == ST_DATA);

  srd_tx_ser #(.BYTE_W(8)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cs_n_s),
    .step      (tx_step),
    .load_data (data_buf),
    .dout      (miso_o),
    .oe        (miso_oe),
    .last_bit  (tx_last)
  );

  assign addr_done = rx_done && (state == ST_ADDR) && (abyte_idx == AB_LAST);
  assign addr_word = {addr_hi, rx_byte};
  assign fetch_go  = addr_done || (tx_last && (state == ST_DATA));

  // Command / address sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      abyte_idx <= '0;
      addr_hi   <= '0;
    end else if (cs_n_s) begin
      state     <= ST_IDLE;
      abyte_idx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: state <= ST_CMD;
        ST_CMD: begin
          if (rx_done) state <= (rx_byte == CMD_READ) ? ST_ADDR : ST_SKIP;
        end
        ST_ADDR: begin
          if (rx_done) begin
            addr_hi   <= rx_byte;
            abyte_idx <= abyte_idx + 1'b1;
            if (abyte_idx == AB_LAST) state <= ST_DATA;
          end
        end
        ST_DATA: state <= ST_DATA;
        ST_SKIP: state <= ST_SKIP;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Array request channel with auto-increment; AW-bit counter wraps to 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      next_addr <= '0;
    end else if (cs_n_s) begin
      pend <= 1'b0;
    end else begin
      if (addr_done) next_addr <= addr_word[AW-1:0];
      if (fetch_go) begin
        pend <= 1'b1;
      end else if (pend && mem_req_ready) begin
        pend      <= 1'b0;
        next_addr <= next_addr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             data_buf <= '0;
    else if (mem_rsp_valid) data_buf <= mem_rsp_data;
  end

  assign mem_req_valid = pend;
  assign mem_req_addr  = next_addr;

endmodule

// File: rtl/srd_read_seq_chk.sv
module srd_read_seq_chk #(
  parameter int AW = 14
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_n,
  input logic            cs_n_s,
  input logic            sclk_fall,
  input logic            miso_o,
  input logic            miso_oe,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [AW-1:0]   mem_req_addr,
  input srd_pkg::state_t state
);
  import srd_pkg::*;

  // R1: a deselected bus stays quiet
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4))
      |-> (!miso_oe && !mem_req_valid));

  // R3: the output bit moves only after a detected falling serial edge
  a_r3_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe && $past(miso_oe) && !$stable(miso_o)) |-> $past(sclk_fall));

  // R7: an unknown command keeps the block silent
  a_r7_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |=> (!mem_req_valid && !miso_oe));

  // R8: a synchronized deselect returns the sequencer to idle
  a_r8_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_s) |=> (state == ST_IDLE && !miso_oe));

  // R10: a stalled request holds valid and address
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !cs_n_s) |=> (mem_req_valid && $stable(mem_req_addr)));

endmodule

bind srd_read_seq srd_read_seq_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cs_n          (cs_n),
  .cs_n_s        (cs_n_s),
  .sclk_fall     (sclk_fall),
  .miso_o        (miso_o),
  .miso_oe       (miso_oe),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .state         (state)
);

// File: tb/srd_read_seq_bench.sv
module srd_read_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 256;
  localparam int AW         = $clog2(DEPTH);
  localparam int HALF       = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sclk = 1'b0;
  logic          cs_n = 1'b1;
  logic          mosi = 1'b0;
  logic          miso_o;
  logic          miso_oe;
  logic          mem_req_valid;
  logic          mem_req_ready;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [7:0]    mem_rsp_data = '0;

  int checks = 0;
  int fails  = 0;
  int req_cnt = 0;
  int cyc = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  srd_read_seq #(.DEPTH(DEPTH)) u_srd_read_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .sclk          (sclk),
    .cs_n          (cs_n),
    .mosi          (mosi),
    .miso_o        (miso_o),
    .miso_oe       (miso_oe),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  assign mem_req_ready = !stall_mode || (cyc % 4 == 3);

  // Array model: one-cycle response after each handshake
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= pat(int'(mem_req_addr));
      req_cnt       <= req_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx,
                          output bit oe_all, output bit oe_any);
    oe_all = 1'b1;
    oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      ticks(HALF);
      rx[i] = miso_o;
      oe_all &= miso_oe;
      oe_any |= miso_oe;
      sclk = 1'b1;
      ticks(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic select();
    cs_n = 1'b0;
    ticks(HALF);
  endtask

  task automatic deselect();
    ticks(HALF);
    cs_n = 1'b1;
    ticks(6);
  endtask

  // Command + address; returns whether oe ever rose during header
  task automatic header(input logic [7:0] cmd, input logic [15:0] addr, output bit oe_seen);
    logic [7:0] rx;
    bit a, b;
    oe_seen = 1'b0;
    spi_byte(cmd, rx, a, b);        oe_seen |= b;
    spi_byte(addr[15:8], rx, a, b); oe_seen |= b;
    spi_byte(addr[7:0], rx, a, b);  oe_seen |= b;
  endtask

  task automatic read_stream(input logic [15:0] addr, input int n, input logic [7:0] fill,
                             input string req);
    logic [7:0] rx;
    bit oe_all, oe_any, hdr_oe;
    int base;
    base = req_cnt;
    select();
    header(8'h03, addr, hdr_oe);
    check(!hdr_oe, "R3 oe low in header", int'(hdr_oe), 0);
    for (int k = 0; k < n; k++) begin
      int loc = (int'(addr) + k) % DEPTH;
      spi_byte(fill ^ 8'(k), rx, oe_all, oe_any);
      check(rx == pat(loc), req, int'(rx), int'(pat(loc)));
      check(oe_all, "R3 oe high in data", int'(oe_all), 1);
    end
    ticks(HALF);
    check(req_cnt - base == n + 1, "R9 request count", req_cnt - base, n + 1);
    deselect();
    check(!miso_oe, "R1 oe low after deselect", int'(miso_oe), 0);
  endtask

  task automatic t_reset();
    ticks(4);
    check(!miso_oe, "R1 reset oe", int'(miso_oe), 0);
    check(!mem_req_valid, "R1 reset request", int'(mem_req_valid), 0);
  endtask

  task automatic t_basic();
    read_stream(16'h0010, 4, 8'h00, "R2/R4 basic stream");
  endtask

  task automatic t_upper_ignored();
    read_stream(16'hFF05, 2, 8'h00, "R2 upper address bits ignored");
  endtask

  task automatic t_wrap();
    read_stream(16'h00FE, 4, 8'h00, "R5 wrap to zero");
  endtask

  task automatic t_mosi_ignored();
    read_stream(16'h0040, 3, 8'hFF, "R6 data-phase input ignored");
    read_stream(16'h0041, 2, 8'hA5, "R6 data-phase input ignored alt");
  endtask

  task automatic t_single();
    read_stream(16'h0033, 1, 8'h00, "R9 single byte");
  endtask

  task automatic t_bad_cmd();
    logic [7:0] rx;
    bit oe_seen, a, b;
    int base;
    base = req_cnt;
    select();
    header(8'h0B, 16'h0010, oe_seen);
    spi_byte(8'h00, rx, a, b);
    oe_seen |= b;
    deselect();
    check(!oe_seen, "R7 oe silent on unknown command", int'(oe_seen), 0);
    check(req_cnt == base, "R7 no request on unknown command", req_cnt - base, 0);
    read_stream(16'h0012, 2, 8'h00, "R7 next transaction decodes");
  endtask

  task automatic t_abort();
    bit oe_seen;
    select();
    header(8'h03, 16'h0020, oe_seen);
    for (int i = 0; i < 4; i++) begin
      ticks(HALF); sclk = 1'b1; ticks(HALF); sclk = 1'b0;
    end
    cs_n = 1'b1;
    ticks(5);
    check(!miso_oe, "R8 oe drops on abort", int'(miso_oe), 0);
    ticks(4);
    read_stream(16'h0020, 2, 8'h00, "R8 read after abort");
  endtask

  task automatic t_stall();
    stall_mode = 1'b1;
    read_stream(16'h0070, 5, 8'h00, "R10 stream under stalls");
    stall_mode = 1'b0;
  endtask

  initial begin
    ticks(3);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_upper_ignored();
    t_wrap();
    t_mosi_ignored();
    t_single();
    t_bad_cmd();
    t_abort();
    t_stall();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule